// File: doc/BRIEF.md
# Software-Driven I2C Line Port

This peripheral gives software direct control of the two open-drain wires of an I2C bus, so that start and stop conditions, bits and acknowledges can all be produced by program code toggling the lines. It has no protocol engine, no byte shifter and no clock-stretch handling; software owns all timing.

Each wire has one release bit. A release bit of 1 turns the output enable off, so the board pull-up takes the wire high. A release bit of 0 turns the enable on with a low output value, pulling the wire down. Software raises release bits through the set register and lowers them through a separate clear register. Only bits written as 1 act, so one wire can change without a read-modify-write. Reading the set register's offset returns the actual wire levels after a two-flop synchroniser. Those levels can differ from the release bits when another device holds a wire low.

The register side is an APB slave that never waits. Write data acts at the clock edge that ends the access phase. Read data is combinational from the synchronised levels.

Top module: `i2c_bitbang_port`

## Requirements
- R1: After reset both release bits are 0, so `sda_oe` and `scl_oe` are both 1 and both wires are pulled low.
- R2: `sda_o` and `scl_o` are always 0. Each output enable (active high) is the inverse of its release bit.
- R3: An APB write to offset 0x0 sets the release bit of every wire whose data bit is 1. Bit 1 is SDA and bit 0 is SCL. The new enables appear in the cycle after the access phase.
- R4: An APB write to offset 0x4 clears the release bit of every wire whose data bit is 1, using the same bit positions.
- R5: A data bit of 0 in a write to 0x0 or 0x4 leaves that wire's release bit unchanged. Write data bits 31:2 are ignored.
- R6: A read at offset 0x0 returns the synchronised SDA level in bit 1 and the SCL level in bit 0. A level change on `sda_i`/`scl_i` is visible after exactly two clock edges.
- R7: Reads at offset 0x4 or at any unmapped offset return zero, and bits 31:2 of every read are zero.
- R8: `pready` is always 1, so every transfer completes with zero wait states.
- R9: Writes to unmapped offsets change neither release bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (12) | Byte offset within the block |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data |
| pready | output | 1 | Transfer ready, held high |
| sda_i | input | 1 | Level seen on the SDA wire |
| sda_o | output | 1 | SDA output value, constant low |
| sda_oe | output | 1 | SDA pull-down enable, active high |
| scl_i | input | 1 | Level seen on the SCL wire |
| scl_o | output | 1 | SCL output value, constant low |
| scl_oe | output | 1 | SCL pull-down enable, active high |

## Verification
The bench sets and clears one wire at a time and checks that the other wire does not move. A design that treats a zero data bit as "clear" or that swaps the bit order would disturb the wrong wire. It writes to unmapped offsets and sends data with only the upper bits set, which exposes loose address decoding or an unmasked data path. A second device is modelled holding SDA low while the port releases it, so a design that echoes its release bits instead of the wire levels would read back 1. The bench also counts edges after a wire change to catch a synchroniser that is one stage too short or too long.

// File: rtl/i2cbb_pkg.sv
package i2cbb_pkg;
    localparam int LINE_CNT = 2;
    localparam int SDA_BIT  = 1;
    localparam int SCL_BIT  = 0;

    typedef logic [LINE_CNT-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t rel;
    } line_state_t;
endpackage

// File: rtl/i2cbb_sync.sv
module i2cbb_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/i2cbb_decode.sv
module i2cbb_decode
    import i2cbb_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int SET_OFS = 0,
    parameter int CLR_OFS = 4
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  line_vec_t         wbits,
    output line_vec_t         set_mask,
    output line_vec_t         clr_mask,
    output logic              rd_lvl
);
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFS);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

    logic wr_acc;

    always_comb begin
        wr_acc   = psel && penable && pwrite;
        set_mask = (wr_acc && paddr == SET_A) ? wbits : '0;
        clr_mask = (wr_acc && paddr == CLR_A) ? wbits : '0;
        rd_lvl   = psel && !pwrite && paddr == SET_A;
    end
endmodule

// File: rtl/i2cbb_lines.sv
module i2cbb_lines
    import i2cbb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t set_mask,
    input  line_vec_t clr_mask,
    output line_vec_t rel
);
    line_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rel = (st_q.rel | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rel = st_q.rel;
endmodule

// File: rtl/i2c_bitbang_port.sv
module i2c_bitbang_port
    import i2cbb_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe,
    input  logic              scl_i,
    output logic              scl_o,
    output logic              scl_oe
);
    localparam int PAD_W = DATA_W - LINE_CNT;

    line_vec_t pins_raw, pins_sync, set_mask, clr_mask, rel, oe;
    logic      rd_lvl;
    logic      unused_wdata_hi;

    assign unused_wdata_hi = ^pwdata[DATA_W-1:LINE_CNT];

    always_comb begin
        pins_raw          = '0;
        pins_raw[SDA_BIT] = sda_i;
        pins_raw[SCL_BIT] = scl_i;
    end

    i2cbb_sync #(.W(LINE_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .din   (pins_raw),
        .dout  (pins_sync)
    );

    i2cbb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .wbits    (pwdata[LINE_CNT-1:0]),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .rd_lvl   (rd_lvl)
    );

    i2cbb_lines u_lines (
        .clk      (pclk),
        .rst_n    (presetn),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .rel      (rel)
    );

    for (genvar g = 0; g < LINE_CNT; g++) begin : g_oe
        assign oe[g] = ~rel[g];
    end

    assign sda_oe = oe[SDA_BIT];
    assign scl_oe = oe[SCL_BIT];
    assign sda_o  = 1'b0;
    assign scl_o  = 1'b0;
    assign pready = 1'b1;
    assign prdata = rd_lvl ? {{PAD_W{1'b0}}, pins_sync} : '0;
endmodule

// File: rtl/i2cbb_port_chk.sv
module i2cbb_port_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic              pready,
    input logic              sda_i,
    input logic              sda_oe,
    input logic              scl_i,
    input logic              scl_oe
);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(4);

    logic [1:0] up_cnt;
    logic       wr;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) up_cnt <= '0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    assign wr = psel && penable && pwrite;

    // R3
    set_sda_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && paddr == A_SET && pwdata[1]) |=> !sda_oe);
    // R3
    set_scl_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && paddr == A_SET && pwdata[0]) |=> !scl_oe);
    // R4
    clr_sda_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && paddr == A_CLR && pwdata[1]) |=> sda_oe);
    // R4
    clr_scl_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && paddr == A_CLR && pwdata[0]) |=> scl_oe);
    // R9
    oe_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
        !(wr && (paddr == A_SET || paddr == A_CLR)) |=> $stable({sda_oe, scl_oe}));
    // R6
    rd_level_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (up_cnt >= 2'd2 && psel && !pwrite && paddr == A_SET)
        |-> prdata[1:0] == {$past(sda_i, 2), $past(scl_i, 2)});
    // R7
    rd_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && paddr != A_SET) |-> prdata == '0);
    // R7
    rd_pad_chk: assert property (@(posedge pclk) disable iff (!presetn)
        prdata[DATA_W-1:2] == '0);
    // R8
    ready_chk: assert property (@(posedge pclk) disable iff (!presetn)
        pready);
endmodule

bind i2c_bitbang_port i2cbb_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .pready  (pready),
    .sda_i   (sda_i),
    .sda_oe  (sda_oe),
    .scl_i   (scl_i),
    .scl_oe  (scl_oe)
);

// File: tb/sim_i2c_bitbang_port.sv
`timescale 1ns/1ps
module sim_i2c_bitbang_port;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        sda_o, sda_oe, scl_o, scl_oe;
    logic        ext_sda_low = 1'b0, ext_scl_low = 1'b0;
    logic        sda_i, scl_i;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        string       req;
        logic [31:0] exp;
    } item_t;
    item_t sb_q[$];

    always #2 pclk = ~pclk;

    assign sda_i = !(sda_oe || ext_sda_low);
    assign scl_i = !(scl_oe || ext_scl_low);

    i2c_bitbang_port u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .sda_i(sda_i), .sda_o(sda_o), .sda_oe(sda_oe),
        .scl_i(scl_i), .scl_o(scl_o), .scl_oe(scl_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lvl_exp();
        logic s, c;
        s = !(sda_oe || ext_sda_low);
        c = !(scl_oe || ext_scl_low);
        return {30'b0, s, c};
    endfunction

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(posedge pclk); #1;
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(posedge pclk); #1;
        penable = 1;
        @(posedge pclk); #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    // expected value is pushed by the driver; monitor compares during access
    task automatic apb_read(input logic [11:0] a, input string req, input logic [31:0] exp);
        repeat (3) @(posedge pclk);
        #1;
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        sb_q.push_back('{req, exp});
        @(posedge pclk); #1;
        penable = 1;
        @(posedge pclk); #1;
        psel = 0; penable = 0;
    endtask

    always @(negedge pclk) begin
        if (psel && penable && !pwrite) begin
            if (sb_q.size() == 0) begin
                chk("scoreboard", 32'h1, 32'h0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(it.req, prdata, it.exp);
                chk("R8 pready", {31'b0, pready}, 32'h1);
            end
        end
    end

    task automatic chk_oe(input string req, input logic sda_e, input logic scl_e);
        @(negedge pclk);
        chk(req, {30'b0, sda_oe, scl_oe}, {30'b0, sda_e, scl_e});
        chk("R2 outputs low", {30'b0, sda_o, scl_o}, 32'h0);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge pclk);
        #1 presetn = 1;
        // R1 reset: both enables asserted
        chk_oe("R1 reset enables", 1, 1);
        apb_read(12'h000, "R6 read after reset", 32'h0);
        // R3 set SCL only
        apb_write(12'h000, 32'h1);
        chk_oe("R3 set scl", 1, 0);
        apb_read(12'h000, "R6 scl released", lvl_exp());
        chk("R6 level value", lvl_exp(), 32'h1);
        // R3 set SDA; R5 SCL untouched by zero bit
        apb_write(12'h000, 32'h2);
        chk_oe("R5 set sda keeps scl", 0, 0);
        apb_read(12'h000, "R6 both released", 32'h3);
        // R4 clear SCL, R5 SDA unchanged
        apb_write(12'h004, 32'h1);
        chk_oe("R4 clear scl", 0, 1);
        apb_read(12'h000, "R6 sda only high", 32'h2);
        // R5 zero writes and upper data bits ignored
        apb_write(12'h000, 32'h0);
        chk_oe("R5 zero set write", 0, 1);
        apb_write(12'h004, 32'hFFFF_FFFC);
        chk_oe("R5 upper bits on clear", 0, 1);
        apb_write(12'h000, 32'hFFFF_FFFC);
        chk_oe("R5 upper bits on set", 0, 1);
        // R9 unmapped writes
        apb_write(12'h008, 32'h3);
        chk_oe("R9 write 0x8", 0, 1);
        apb_write(12'h00C, 32'h3);
        chk_oe("R9 write 0xC", 0, 1);
        apb_write(12'h404, 32'h3);
        chk_oe("R9 write 0x404", 0, 1);
        // R7 reads elsewhere return zero
        apb_read(12'h004, "R7 read 0x4", 32'h0);
        apb_read(12'h010, "R7 read 0x10", 32'h0);
        apb_read(12'hFFC, "R7 read 0xFFC", 32'h0);
        // R6 line level, not release state: another device holds SDA low
        repeat (3) @(posedge pclk);
        #1;
        psel = 1; pwrite = 0; paddr = 12'h000; penable = 0;
        @(negedge pclk);
        chk("R6 before hold", prdata, 32'h2);
        @(posedge pclk); #1;
        ext_sda_low = 1;
        @(posedge pclk);
        @(negedge pclk);
        chk("R6 one edge after change", prdata, 32'h2);
        @(negedge pclk);
        chk("R6 two edges after change", prdata, 32'h0);
        #1 psel = 0;
        apb_read(12'h000, "R6 held low by other device", 32'h0);
        ext_sda_low = 0;
        // R4 clear both, back to reset-like state
        apb_write(12'h000, 32'h3);
        chk_oe("R3 set both", 0, 0);
        apb_write(12'h004, 32'h3);
        chk_oe("R4 clear both", 1, 1);
        apb_read(12'h000, "R6 both driven low", 32'h0);
        // R1 reset in mid-run
        apb_write(12'h000, 32'h3);
        @(posedge pclk); #1 presetn = 0;
        @(negedge pclk);
        chk("R1 async reset", {30'b0, sda_oe, scl_oe}, 32'h3);
        @(posedge pclk); #1 presetn = 1;
        repeat (4) @(posedge pclk);
        chk("R6 scoreboard drained", sb_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule